// File: doc/BRIEF.md
# Phase-Gated Time Interval Counter

This block measures the phase offset between a reference pulse and a divided oscillator. It counts the clock cycles during which an asynchronous phase window is high. The counter runs from a 100 MHz clock, so each count stands for 10 ns of offset. The window acts only on the counter's enable. The clock reaches every flip-flop ungated. In a cycle where the enable is low, the counter holds its value. In a cycle where the enable is high, the counter increments.

A one-second tick copies the running count to an output register and clears the counter, both in the same clock cycle. The cycle in which the tick arrives is still counted, and it is counted only once. The output register carries a saturation flag. The per-second readings are added into a signed accumulator. An update tick, typically every 120 seconds, hands out the sum and clears the accumulator. The window can pass through a shift-register synchronizer of 0, 2 or 3 stages, which the `SYNC_STAGES` parameter selects. The synchronizer reduces metastable states.

Top module: `phase_tic`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `sec_count`, `sec_ovf`, `sec_valid`, `sum_out` and `sum_valid` are all zero.
- R2: Each rising clock edge on which the synchronized window is high adds exactly one to the count. A window that is high for H clock edges, and has settled before the tick, yields `sec_count` = H.
- R3: On a `sec_tick` edge the counter's value, including that edge's own increment, is captured and the counter is cleared in the same edge. A window that spans the tick is therefore split between two readings whose sum equals its length in edges.
- R4: `sec_valid` is high for exactly the one cycle after each `sec_tick` edge, and is low otherwise.
- R5: The count saturates at 2^CNT_W-1 and does not wrap. A reading that saturated has `sec_ovf` = 1. The next second starts from zero with the flag cleared.
- R6: The window reaches the enable after exactly `SYNC_STAGES` clock edges. A window that rises and stays high through a tick taken on its (M+1)-th high edge reads M+1-SYNC_STAGES.
- R7: On an `upd_tick` edge, `sum_out` takes the sum of all readings since the previous update, and `sum_valid` is high for exactly the next cycle.
- R8: A reading whose `sec_valid` cycle coincides with `upd_tick` is included in that sum. After an update the accumulator restarts from zero.
- R9: A window that stays low through a whole second yields a reading of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz counting clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phase_win | input | 1 | Asynchronous phase-detector window |
| sec_tick | input | 1 | One-cycle capture-and-clear pulse, once per second |
| upd_tick | input | 1 | One-cycle pulse at the end of a loop update interval |
| sec_count | output | CNT_W | Count captured at the last second tick |
| sec_ovf | output | 1 | The captured count saturated |
| sec_valid | output | 1 | One-cycle strobe for a new captured count |
| sum_out | output | ACC_W | Signed sum of readings over the update interval |
| sum_valid | output | 1 | One-cycle strobe for a new sum |

## Verification
The assertions assume that `sec_tick` and `upd_tick` are single-cycle pulses and that `sec_tick` never arrives on two adjacent edges. The window is the only input allowed to change at any time. The stimulus drives every input half a period away from the sampling edge and keeps each tick one cycle wide. It spaces the second ticks at least a few cycles apart, so that the strobe properties describe the real usage. For the saturation case the bench narrows the counter, so the limit is reached in a few hundred cycles.

// File: rtl/phase_tic.sv
module phase_tic #(
  parameter int CNT_W       = 24,
  parameter int ACC_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    phase_win,
  input  logic                    sec_tick,
  input  logic                    upd_tick,
  output logic [CNT_W-1:0]        sec_count,
  output logic                    sec_ovf,
  output logic                    sec_valid,
  output logic signed [ACC_W-1:0] sum_out,
  output logic                    sum_valid
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam int PAD_W = ACC_W - CNT_W;

  logic en;

  generate
    if (SYNC_STAGES == 0) begin : g_nosync
      assign en = phase_win;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], phase_win};
      end
      assign en = sync_q[SYNC_STAGES-1];
    end
  endgenerate

  logic [CNT_W-1:0] cnt;
  logic             ovf;
  logic             at_max;
  logic [CNT_W-1:0] cnt_nxt;
  logic             ovf_nxt;

  assign at_max  = (cnt == CNT_MAX);
  assign cnt_nxt = (en && !at_max) ? cnt + 1'b1 : cnt;
  assign ovf_nxt = ovf | (en & at_max);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      ovf       <= 1'b0;
      sec_count <= '0;
      sec_ovf   <= 1'b0;
      sec_valid <= 1'b0;
    end else begin
      sec_valid <= sec_tick;
      if (sec_tick) begin
        sec_count <= cnt_nxt;
        sec_ovf   <= ovf_nxt;
        cnt       <= '0;
        ovf       <= 1'b0;
      end else begin
        cnt <= cnt_nxt;
        ovf <= ovf_nxt;
      end
    end
  end

  logic signed [ACC_W-1:0] acc;
  logic signed [ACC_W-1:0] reading;
  logic signed [ACC_W-1:0] acc_nxt;

  assign reading = $signed({{PAD_W{1'b0}}, sec_count});
  assign acc_nxt = sec_valid ? acc + reading : acc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc       <= '0;
      sum_out   <= '0;
      sum_valid <= 1'b0;
    end else begin
      sum_valid <= upd_tick;
      if (upd_tick) begin
        sum_out <= acc_nxt;
        acc     <= '0;
      end else begin
        acc <= acc_nxt;
      end
    end
  end

  initial begin
    assert (SYNC_STAGES == 0 || SYNC_STAGES == 2 || SYNC_STAGES == 3);
    assert (ACC_W > CNT_W);
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !sec_tick) |=> $stable(cnt));

  p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (at_max && !sec_tick) |=> (cnt == CNT_MAX));

  p_ovf_at_max_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_valid && sec_ovf) |-> (sec_count == CNT_MAX));

  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> (cnt == '0 && !ovf));

  p_sec_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> sec_valid);

  p_sec_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_tick |=> !sec_valid);

  p_sum_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    upd_tick |=> (sum_valid && acc == '0));

  p_sum_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_tick |=> (!sum_valid && $stable(sum_out)));
endmodule

// File: tb/phase_tic_tb.sv
module phase_tic_tb;
  localparam int CNT_W = 8;
  localparam int ACC_W = 32;
  localparam int SYNC  = 2;
  localparam int NV    = 6;
  localparam int VEC_H [NV] = '{5, 0, 17, 1, 40, 100};
  localparam int VEC_L [NV] = '{4, 6, 5, 4, 8, 4};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic phase_win = 1'b0, sec_tick = 1'b0, upd_tick = 1'b0;
  logic [CNT_W-1:0] sec_count;
  logic sec_ovf, sec_valid, sum_valid;
  logic signed [ACC_W-1:0] sum_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  phase_tic #(.CNT_W(CNT_W), .ACC_W(ACC_W), .SYNC_STAGES(SYNC)) u_dut (
    .clk(clk), .rst_n(rst_n), .phase_win(phase_win), .sec_tick(sec_tick),
    .upd_tick(upd_tick), .sec_count(sec_count), .sec_ovf(sec_ovf),
    .sec_valid(sec_valid), .sum_out(sum_out), .sum_valid(sum_valid));

  task automatic cyc(input logic w, input logic s, input logic u);
    @(negedge clk);
    phase_win = w; sec_tick = s; upd_tick = u;
  endtask

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    longint exp_sum;
    repeat (3) cyc(0, 0, 0);
    chk("R1 sec_count", sec_count, 0);
    chk("R1 flags", {sec_ovf, sec_valid, sum_valid}, 0);
    chk("R1 sum_out", sum_out, 0);
    cyc(0, 0, 0);
    rst_n = 1'b1;
    cyc(0, 0, 0);
    chk("R1 after release", {sec_valid, sum_valid, sec_ovf}, 0);

    exp_sum = 0;
    for (int i = 0; i < NV; i++) begin
      repeat (VEC_H[i]) cyc(1, 0, 0);
      repeat (VEC_L[i]) cyc(0, 0, 0);
      cyc(0, 1, 0);
      chk("R4 no early strobe", sec_valid, 0);
      cyc(0, 0, 0);
      chk("R2 count", sec_count, VEC_H[i]);
      chk("R4 strobe", sec_valid, 1);
      chk("R5 no ovf", sec_ovf, 0);
      exp_sum += VEC_H[i];
      cyc(0, 0, 0);
      chk("R4 strobe drops", sec_valid, 0);
    end
    cyc(0, 0, 1);
    cyc(0, 0, 0);
    chk("R7 sum", sum_out, exp_sum);
    chk("R7 sum_valid", sum_valid, 1);
    cyc(0, 0, 0);
    chk("R7 sum_valid drops", sum_valid, 0);

    // R6 latency and R3 split across the tick
    repeat (10) cyc(1, 0, 0);
    cyc(1, 1, 0);
    cyc(1, 0, 0);
    chk("R6 latency", sec_count, 11 - SYNC);
    repeat (6) cyc(1, 0, 0);
    repeat (6) cyc(0, 0, 0);
    cyc(0, 1, 0);
    cyc(0, 0, 1);
    chk("R3 remainder", sec_count, 7 + SYNC);
    cyc(0, 0, 0);
    chk("R8 coincident sum", sum_out, 18);
    chk("R8 sum_valid", sum_valid, 1);

    // R9 idle second; R8 accumulator restarted
    repeat (5) cyc(0, 0, 0);
    cyc(0, 1, 0);
    cyc(0, 0, 0);
    chk("R9 idle count", sec_count, 0);
    cyc(0, 0, 0);
    cyc(0, 0, 1);
    cyc(0, 0, 0);
    chk("R8 cleared acc", sum_out, 0);

    // R5 saturation
    repeat (300) cyc(1, 0, 0);
    repeat (5) cyc(0, 0, 0);
    cyc(0, 1, 0);
    cyc(0, 0, 0);
    chk("R5 saturated", sec_count, 255);
    chk("R5 ovf set", sec_ovf, 1);
    repeat (3) cyc(1, 0, 0);
    repeat (5) cyc(0, 0, 0);
    cyc(0, 1, 0);
    cyc(0, 0, 0);
    chk("R5 restart", sec_count, 3);
    chk("R5 ovf cleared", sec_ovf, 0);

    // R1 reset mid-run clears outputs
    rst_n = 1'b0;
    cyc(0, 0, 0);
    cyc(0, 0, 0);
    chk("R1 reset clears", {sec_count, sec_ovf}, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule